// File: doc/BRIEF.md
# Per-Thread Outstanding Address Tracker

This block sits beside the memory-access stage of a multithreaded in-order pipeline and decides whether a new access may go out. It holds a small table of accesses that are in flight. Each entry holds a thread number, a full address and the sequence number of the instruction that owns it. A data-side request whose address is already outstanding for the same thread is held back until that access completes or is squashed. The one exception is a replay from the instruction that already owns the entry. Instruction-side requests skip the table. A per-thread translation-stall input stops every request of that thread.

The verdict is combinational in the request cycle. Table updates from a grant, a completion or a squash happen at the next rising clock edge and are visible from the following cycle. Completion and squash each have a port of their own. A squash takes a thread and a sequence-number threshold. A stall flag on the squash port raises the threshold by one, so the instruction that caused a memory stall keeps its entry.

Top module: `addr_dep_tracker`

## Requirements
- R1: A request whose thread has its `xlat_blocked` bit set is denied, on either side and for any address. It leaves the table unchanged.
- R2: An instruction-side request (`req_iside`=1) from a thread that is not blocked is granted without consulting the table, and it inserts nothing.
- R3: A data-side request that matches no valid entry of its own thread is granted, and its thread, address and sequence number are stored in a free entry.
- R4: A data-side request that matches a valid entry of its thread with an equal sequence number is granted as a replay, and no second entry is created.
- R5: A data-side request that matches a valid entry of its thread with a different sequence number is denied.
- R6: Matching compares all `ADDR_W` address bits and the thread number, so entries of another thread, or an address that differs only in its top bit, never match.
- R7: A completion (`done_valid`) removes the entry of that thread and address. A later request to that address with any sequence number is then granted.
- R8: A completion that matches no entry changes nothing.
- R9: A squash with stall flag 0 and threshold S removes every entry of the squashed thread whose sequence number is greater than S (unsigned). Entries at or below S, and entries of other threads, remain.
- R10: A squash with stall flag 1 uses S+1 as the threshold, compared one bit wider than `SEQ_W`, so an entry holding S+1 survives.
- R11: A data-side request that needs a new entry while all `ENTRIES` entries are valid is denied with `req_ovf`=1. A replay or instruction-side request in that state is still granted, with `req_ovf`=0.
- R12: Outputs are 0 while no request is valid. Reset empties the table. An entry inserted in a cycle is not removed by a squash or completion arriving in that same cycle, because those act only on entries valid before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| xlat_blocked | input | THREADS | Per-thread translation-stall flags |
| req_valid | input | 1 | Request present this cycle |
| req_iside | input | 1 | 1 = instruction-side request, 0 = data-side |
| req_tid | input | TID_W | Requesting thread |
| req_addr | input | ADDR_W | Requested address |
| req_seq | input | SEQ_W | Sequence number of the requesting instruction |
| req_grant | output | 1 | Request may proceed (combinational) |
| req_ovf | output | 1 | Denied because the table is full (combinational) |
| done_valid | input | 1 | An access has completed |
| done_tid | input | TID_W | Thread of the completed access |
| done_addr | input | ADDR_W | Address of the completed access |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Squash threshold S |
| sq_stall | input | 1 | 1 = squash caused by a memory stall (threshold S+1) |

## Verification
The bench targets the replay path first. A design that keyed on the address alone would deny an instruction its own retry, and one that ignored the sequence number would let a younger access pass an older one. It checks the stall squash at exactly S+1, where an off-by-one either wipes the stalling instruction or keeps a younger one. It checks a squash in the same cycle as an insertion, which a design that applied the kill after the write would lose. It checks the full-table boundary, where a replay must still pass but a new address must raise the overflow flag rather than overwrite a live entry. A long pseudo-random sweep over two threads, eight addresses and small sequence numbers then compares every verdict against an arithmetic model of the table.

// File: rtl/adt_pkg.sv
package adt_pkg;

  // Verdict reached for the request presented in the current cycle.
  typedef enum logic [2:0] {
    ADT_IDLE,
    ADT_BLOCKED,
    ADT_ISIDE,
    ADT_REPLAY,
    ADT_CONFLICT,
    ADT_ALLOC,
    ADT_FULL
  } adt_verdict_e;

endpackage

// File: rtl/adt_cam.sv
// Parallel comparison of every table entry against the request, the
// completion and the squash ports.
module adt_cam #(
  parameter int ENTRIES = 8,
  parameter int TID_W   = 1,
  parameter int ADDR_W  = 32,
  parameter int SEQ_W   = 16
) (
  input  logic [ENTRIES-1:0]             ent_v,
  input  logic [ENTRIES-1:0][TID_W-1:0]  ent_tid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
  input  logic [ENTRIES-1:0][SEQ_W-1:0]  ent_seq,
  input  logic [TID_W-1:0]               req_tid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [SEQ_W-1:0]               req_seq,
  input  logic                           done_valid,
  input  logic [TID_W-1:0]               done_tid,
  input  logic [ADDR_W-1:0]              done_addr,
  input  logic                           sq_valid,
  input  logic [TID_W-1:0]               sq_tid,
  input  logic [SEQ_W:0]                 sq_thr,
  output logic [ENTRIES-1:0]             req_hit,
  output logic [ENTRIES-1:0]             req_same_seq,
  output logic [ENTRIES-1:0]             done_hit,
  output logic [ENTRIES-1:0]             sq_kill
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic own_req, own_done, own_sq;
    assign own_req  = ent_v[i] && (ent_tid[i] == req_tid);
    assign own_done = ent_v[i] && (ent_tid[i] == done_tid);
    assign own_sq   = ent_v[i] && (ent_tid[i] == sq_tid);

    assign req_hit[i]      = own_req && (ent_addr[i] == req_addr);
    assign req_same_seq[i] = req_hit[i] && (ent_seq[i] == req_seq);
    assign done_hit[i]     = done_valid && own_done && (ent_addr[i] == done_addr);
    assign sq_kill[i]      = sq_valid && own_sq && ({1'b0, ent_seq[i]} > sq_thr);
  end

endmodule

// File: rtl/adt_free_pick.sv
// Lowest-index free entry finder.
module adt_free_pick #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] ent_v,
  output logic [ENTRIES-1:0] pick,
  output logic               any_free
);

  always_comb begin
    pick     = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!ent_v[i] && !any_free) begin
        pick[i]  = 1'b1;
        any_free = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adt_store.sv
// Entry storage: valid bits under reset, payload written under a per-entry
// enable.
module adt_store #(
  parameter int ENTRIES = 8,
  parameter int TID_W   = 1,
  parameter int ADDR_W  = 32,
  parameter int SEQ_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             ins_en,
  input  logic [ENTRIES-1:0]             clr,
  input  logic [TID_W-1:0]               ins_tid,
  input  logic [ADDR_W-1:0]              ins_addr,
  input  logic [SEQ_W-1:0]               ins_seq,
  output logic [ENTRIES-1:0]             ent_v,
  output logic [ENTRIES-1:0][TID_W-1:0]  ent_tid,
  output logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
  output logic [ENTRIES-1:0][SEQ_W-1:0]  ent_seq
);

  logic [ENTRIES-1:0] v_nxt;

  // Removals act on entries already valid; an insertion targets a free one.
  always_comb begin
    v_nxt = (ent_v & ~clr) | ins_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else        ent_v <= v_nxt;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (ins_en[i]) begin
        ent_tid[i]  <= ins_tid;
        ent_addr[i] <= ins_addr;
        ent_seq[i]  <= ins_seq;
      end
    end
  end

  // R3: an insertion never lands on an entry that is still live.
  a_r3_insert_free: assert property (@(posedge clk) disable iff (!rst_n)
    (|ins_en) |-> ((ins_en & ent_v) == '0));

endmodule

// File: rtl/addr_dep_tracker.sv
module addr_dep_tracker
  import adt_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] xlat_blocked,
  input  logic               req_valid,
  input  logic               req_iside,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SEQ_W-1:0]   req_seq,
  output logic               req_grant,
  output logic               req_ovf,
  input  logic               done_valid,
  input  logic [TID_W-1:0]   done_tid,
  input  logic [ADDR_W-1:0]  done_addr,
  input  logic               sq_valid,
  input  logic [TID_W-1:0]   sq_tid,
  input  logic [SEQ_W-1:0]   sq_seq,
  input  logic               sq_stall
);

  logic [ENTRIES-1:0]             ent_v;
  logic [ENTRIES-1:0][TID_W-1:0]  ent_tid;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0][SEQ_W-1:0]  ent_seq;

  logic [ENTRIES-1:0] req_hit, req_same_seq, done_hit, sq_kill;
  logic [ENTRIES-1:0] pick, ins_en, clr;
  logic               any_free;
  logic [SEQ_W:0]     sq_thr;
  adt_verdict_e       verdict;

  // One bit wider so S+1 never wraps to zero.
  assign sq_thr = {1'b0, sq_seq} + {{SEQ_W{1'b0}}, sq_stall};

  adt_cam #(
    .ENTRIES(ENTRIES), .TID_W(TID_W), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
  ) u_cam (
    .ent_v(ent_v), .ent_tid(ent_tid), .ent_addr(ent_addr), .ent_seq(ent_seq),
    .req_tid(req_tid), .req_addr(req_addr), .req_seq(req_seq),
    .done_valid(done_valid), .done_tid(done_tid), .done_addr(done_addr),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_thr(sq_thr),
    .req_hit(req_hit), .req_same_seq(req_same_seq),
    .done_hit(done_hit), .sq_kill(sq_kill)
  );

  adt_free_pick #(.ENTRIES(ENTRIES)) u_pick (
    .ent_v(ent_v), .pick(pick), .any_free(any_free)
  );

  always_comb begin
    if (!req_valid)                verdict = ADT_IDLE;
    else if (xlat_blocked[req_tid]) verdict = ADT_BLOCKED;
    else if (req_iside)            verdict = ADT_ISIDE;
    else if (|req_hit)             verdict = (|req_same_seq) ? ADT_REPLAY : ADT_CONFLICT;
    else if (any_free)             verdict = ADT_ALLOC;
    else                           verdict = ADT_FULL;
  end

  always_comb begin
    req_grant = (verdict == ADT_ISIDE) || (verdict == ADT_REPLAY) ||
                (verdict == ADT_ALLOC);
    req_ovf   = (verdict == ADT_FULL);
    ins_en    = (verdict == ADT_ALLOC) ? pick : '0;
    clr       = done_hit | sq_kill;
  end

  adt_store #(
    .ENTRIES(ENTRIES), .TID_W(TID_W), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins_en(ins_en), .clr(clr),
    .ins_tid(req_tid), .ins_addr(req_addr), .ins_seq(req_seq),
    .ent_v(ent_v), .ent_tid(ent_tid), .ent_addr(ent_addr), .ent_seq(ent_seq)
  );

  // R1: a stalled thread never receives a grant.
  a_r1_blocked_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_blocked[req_tid]) |-> !req_grant);

  // R2: an instruction-side request alone leaves the table untouched.
  a_r2_iside_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_iside && !done_valid && !sq_valid) |=> $stable(ent_v));

  // R3: a fresh data-side grant adds exactly one entry.
  a_r3_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_iside && req_grant && !(|req_hit) && !done_valid && !sq_valid)
    |=> ($countones(ent_v) == $past($countones(ent_v)) + 1));

  // R4: a replay does not add an entry.
  a_r4_replay_no_add: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_iside && (|req_same_seq) && !done_valid && !sq_valid)
    |=> $stable(ent_v));

  // R5: at most one entry ever holds a given thread and address.
  a_r5_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_hit));

  // R9: a squash never grows the table unless a grant inserts.
  a_r9_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !req_valid) |=> ($countones(ent_v) <= $past($countones(ent_v))));

  // R11: overflow only when every entry is live, and never with a grant.
  a_r11_no_overflow_grant: assert property (@(posedge clk) disable iff (!rst_n)
    req_ovf |-> (!req_grant && (&ent_v)));

  // R12: no verdict output without a request.
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_grant && !req_ovf));

endmodule

// File: tb/addr_dep_tracker_bench.sv
`timescale 1ns/1ps
module addr_dep_tracker_bench;

  localparam int TH = 2;
  localparam int EN = 8;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int TW = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TH-1:0] xlat_blocked;
  logic          req_valid, req_iside;
  logic [TW-1:0] req_tid;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_seq;
  logic          req_grant, req_ovf;
  logic          done_valid;
  logic [TW-1:0] done_tid;
  logic [AW-1:0] done_addr;
  logic          sq_valid;
  logic [TW-1:0] sq_tid;
  logic [SW-1:0] sq_seq;
  logic          sq_stall;

  always #4 clk = ~clk;

  addr_dep_tracker #(.THREADS(TH), .ENTRIES(EN), .ADDR_W(AW), .SEQ_W(SW)) u_addr_dep_tracker (
    .clk(clk), .rst_n(rst_n), .xlat_blocked(xlat_blocked),
    .req_valid(req_valid), .req_iside(req_iside), .req_tid(req_tid),
    .req_addr(req_addr), .req_seq(req_seq),
    .req_grant(req_grant), .req_ovf(req_ovf),
    .done_valid(done_valid), .done_tid(done_tid), .done_addr(done_addr),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_stall(sq_stall)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference table built from the requirements.
  bit            mv   [EN];
  int            mtid [EN];
  logic [AW-1:0] maddr[EN];
  logic [SW-1:0] mseq [EN];

  logic [31:0] lfsr = 32'h1d2c_3b4a;

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [2:0] k);
    return {k[2], 31'h0} | (32'h10 + 32'(k[1:0]) * 32'd4);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < EN; i++) mv[i] = 1'b0;
  endtask

  task automatic cycle(input bit rv, input bit ri, input int rt,
                       input logic [AW-1:0] ra, input logic [SW-1:0] rs,
                       input bit dv, input int dt, input logic [AW-1:0] da,
                       input bit sv, input int st, input logic [SW-1:0] ss,
                       input bit sst, input logic [TH-1:0] blk);
    bit eg, eo, ins;
    int hit, nfree, slot;
    string tag;
    logic [SW:0] thr;
    bit kill[EN];
    @(negedge clk);
    req_valid = rv; req_iside = ri; req_tid = TW'(rt); req_addr = ra; req_seq = rs;
    done_valid = dv; done_tid = TW'(dt); done_addr = da;
    sq_valid = sv; sq_tid = TW'(st); sq_seq = ss; sq_stall = sst;
    xlat_blocked = blk;
    #2;
    hit = -1; nfree = 0; slot = -1;
    for (int i = 0; i < EN; i++) begin
      if (mv[i] && mtid[i] == rt && maddr[i] == ra) hit = i;
      if (!mv[i]) begin
        nfree++;
        if (slot < 0) slot = i;
      end
    end
    eg = 1'b0; eo = 1'b0; ins = 1'b0; tag = "R12";
    if (!rv)            tag = "R12";
    else if (blk[rt])   tag = "R1";
    else if (ri)        begin eg = 1'b1; tag = "R2"; end
    else if (hit >= 0)  begin
      if (mseq[hit] == rs) begin eg = 1'b1; tag = "R4"; end
      else tag = "R5";
    end
    else if (nfree > 0) begin eg = 1'b1; ins = 1'b1; tag = "R3"; end
    else                begin eo = 1'b1; tag = "R11"; end
    checks++;
    if (req_grant !== eg || req_ovf !== eo) begin
      fails++;
      $display("FAIL %s: grant/ovf actual %b/%b expected %b/%b (tid %0d addr %h seq %0d)",
               tag, req_grant, req_ovf, eg, eo, rt, ra, rs);
    end
    thr = {1'b0, ss} + (sst ? 17'd1 : 17'd0);
    for (int i = 0; i < EN; i++)
      kill[i] = mv[i] && ((dv && mtid[i] == dt && maddr[i] == da) ||
                          (sv && mtid[i] == st && {1'b0, mseq[i]} > thr));
    for (int i = 0; i < EN; i++) if (kill[i]) mv[i] = 1'b0;
    if (ins) begin
      mv[slot] = 1'b1; mtid[slot] = rt; maddr[slot] = ra; mseq[slot] = rs;
    end
  endtask

  task automatic data_req(input int t, input logic [AW-1:0] a, input logic [SW-1:0] s);
    cycle(1, 0, t, a, s, 0, 0, '0, 0, 0, '0, 0, '0);
  endtask

  task automatic print_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      print_summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xlat_blocked = '0;
    req_valid = 0; req_iside = 0; req_tid = '0; req_addr = '0; req_seq = '0;
    done_valid = 0; done_tid = '0; done_addr = '0;
    sq_valid = 0; sq_tid = '0; sq_seq = '0; sq_stall = 0;
    model_clear();
    repeat (3) @(negedge clk);
    // R12 reset state: no outputs while idle.
    checks++;
    if (req_grant !== 1'b0 || req_ovf !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset: grant/ovf actual %b/%b expected 0/0", req_grant, req_ovf);
    end
    rst_n = 1'b1;

    data_req(0, 32'h100, 16'd5);                 // R3 fresh grant
    data_req(0, 32'h100, 16'd5);                 // R4 replay
    data_req(0, 32'h100, 16'd6);                 // R5 conflict
    data_req(1, 32'h100, 16'd6);                 // R6 other thread
    data_req(0, 32'h8000_0100, 16'd6);           // R6 top address bit
    cycle(1, 1, 0, 32'h100, 16'd9, 0, 0, '0, 0, 0, '0, 0, '0);   // R2
    data_req(0, 32'h100, 16'd9);                 // R2 nothing inserted: still conflict
    cycle(1, 0, 0, 32'h200, 16'd1, 0, 0, '0, 0, 0, '0, 0, 2'b01); // R1 data
    cycle(1, 1, 0, 32'h200, 16'd1, 0, 0, '0, 0, 0, '0, 0, 2'b01); // R1 iside
    data_req(0, 32'h200, 16'd2);                 // R1 blocked one left no entry
    cycle(0, 0, 0, '0, '0, 1, 0, 32'h100, 0, 0, '0, 0, '0);      // R7 completion
    data_req(0, 32'h100, 16'd6);                 // R7 now granted
    cycle(0, 0, 0, '0, '0, 1, 1, 32'h999, 0, 0, '0, 0, '0);      // R8 stray completion
    data_req(1, 32'h100, 16'd7);                 // R8 entry survived
    cycle(0, 0, 0, '0, '0, 0, 0, '0, 1, 0, 16'd5, 0, '0);        // R9 squash t0 > 5
    data_req(0, 32'h100, 16'd7);                 // R9 removed
    data_req(1, 32'h100, 16'd7);                 // R9 other thread kept
    data_req(0, 32'h200, 16'd3);                 // R9 seq 2 kept
    cycle(0, 0, 0, '0, '0, 0, 0, '0, 1, 0, 16'd6, 1, '0);        // R10 stall squash
    data_req(0, 32'h100, 16'd8);                 // R10 seq 7 survived
    cycle(0, 0, 0, '0, '0, 0, 0, '0, 1, 0, 16'd6, 0, '0);        // R9 plain squash
    data_req(0, 32'h100, 16'd8);                 // R9 seq 7 removed
    cycle(1, 0, 0, 32'h300, 16'd20, 0, 0, '0, 1, 0, 16'd0, 0, '0); // R12 same cycle
    data_req(0, 32'h300, 16'd21);                // R12 insertion kept
    data_req(0, 32'h200, 16'd9);                 // R12 old entry squashed
    for (int k = 0; k < 5; k++) data_req(1, 32'h400 + 32'(k), 16'd1); // fill
    data_req(1, 32'h500, 16'd1);                 // R11 overflow
    data_req(1, 32'h400, 16'd1);                 // R11 replay still granted
    cycle(1, 1, 1, 32'h500, 16'd1, 0, 0, '0, 0, 0, '0, 0, '0);   // R11 iside granted
    @(negedge clk); rst_n = 1'b0; model_clear();
    @(negedge clk); rst_n = 1'b1;
    data_req(1, 32'h400, 16'd9);                 // R12 reset emptied table

    for (int n = 0; n < 4000; n++) begin
      lfsr = next_rand(lfsr);
      cycle(lfsr[1:0] != 2'b00, lfsr[4:2] == 3'b000, int'(lfsr[5]),
            addr_of(lfsr[8:6]), SW'(lfsr[11:9]),
            lfsr[13:12] == 2'b00, int'(lfsr[14]), addr_of(lfsr[17:15]),
            lfsr[21:18] == 4'b0000, int'(lfsr[22]), SW'(lfsr[25:23]), lfsr[26],
            (lfsr[29:27] == 3'b000) ? lfsr[31:30] : 2'b00);
    end

    finished = 1'b1;
    print_summary();
    $finish;
  end

endmodule